// File: doc/BRIEF.md
# Decaying Step-Size Update Generator

This block supplies the shared update term for a sign-data adaptive filter. Each time a new error sample arrives, it multiplies that error by the current learning rate, rounds the product back to the error's scale, and presents the result for one cycle. Every tap of the filter then adds or subtracts this single term according to the sign of its own reference sample. Because the rate is folded in here, the whole filter needs only one multiplier for adaptation.

The learning rate is not a constant. It starts near 0.1 and follows a falling curve shaped like 1/n. The curve is built from three straight segments, and the rate then settles at a floor near 0.001 after 1000 accepted samples. A restart input brings the schedule back to its starting point, so the filter can be retrained after a change in conditions.

Top module: `stepgen_top`

## Requirements
- R1: After reset, updValid is 0 and the step count is 0. The first sample accepted after reset uses alpha = 6554, which is 0.1 as an unsigned fraction scaled by 2^16.
- R2: A strobe on sampleValid with restart low produces updValid = 1 on the next cycle, for that cycle only. updTerm is then floor((errIn*alpha + 32768) / 65536) in signed 16-bit form, which is the product rounded half up.
- R3: Alpha is kept with 8 extra fraction bits, so acc = alpha*256. The value used is acc/256, truncated. For a sample accepted at step count n, where n is below 1000 and n+1 is not a breakpoint, acc is reduced after use by 27919 when n < 50, by 1341 when 50 <= n < 200, and by 79 when 200 <= n < 1000.
- R4: When the step count reaches 50, acc is loaded with 1101*256. When it reaches 200, acc is loaded with 315*256.
- R5: When the step count reaches 1000, acc is loaded with 66*256. The count then saturates, and alpha stays at 66 (about 0.001) for every later sample.
- R6: restart = 1 sets the step count to 0 and acc to 6554*256, and it takes priority over a strobe in the same cycle. That strobe produces no output (updValid = 0 on the next cycle).
- R7: Between restarts alpha never increases, and it never drops below 66.
- R8: In a cycle without an accepted strobe, the next cycle has updValid = 0 and updTerm unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Restart the learning-rate schedule |
| sampleValid | input | 1 | A new error sample is present |
| errIn | input | 16 | Signed error sample |
| updTerm | output | 16 | Signed rounded product of alpha and error |
| updValid | output | 1 | updTerm is new this cycle |

## Verification
The checker assumes restart and sampleValid are synchronous single-cycle qualifiers, and that errIn may take any 16-bit value, including -32768. It also assumes nothing about how often strobes arrive. The stimulus changes inputs only on the inactive clock edge. It spaces strobes with idle cycles so that the hold behaviour can be observed, and it drives the most negative, most positive, zero and unit errors at every stage of the schedule. Restart is exercised both alone and together with a strobe.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

  localparam int NUM_SEG = 3;
  localparam int SEG_SEL_W = $clog2(NUM_SEG);

  // segment table: first step, start alpha (Q0.16), per-step decrement (1/256 LSB)
  localparam int unsigned SEG_BREAK [NUM_SEG] = '{0, 50, 200};
  localparam int unsigned SEG_START [NUM_SEG] = '{6554, 1101, 315};
  localparam int unsigned SEG_DEC   [NUM_SEG] = '{27919, 1341, 79};
  localparam int unsigned FLOOR_ALPHA = 66;

  typedef struct packed {
    logic                 restart;
    logic                 capture;
    logic                 stepDec;
    logic                 loadStart;
    logic                 loadFloor;
    logic [SEG_SEL_W-1:0] segSel;
  } stepCtl_t;

endpackage

// File: rtl/stepgen_ctrl.sv
module stepgen_ctrl
  import stepgen_pkg::*;
#(
  parameter int LAST_STEP = 1000,
  localparam int CNT_W = $clog2(LAST_STEP + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     restart,
  input  logic     sampleValid,
  output stepCtl_t ctl
);

  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             accept;
  logic             atEnd;
  logic [NUM_SEG-1:0] inSeg;
  logic [NUM_SEG-1:0] hitBreak;
  logic [SEG_SEL_W-1:0] segNow;
  logic [SEG_SEL_W-1:0] breakIdx;

  assign accept  = sampleValid & ~restart;
  assign atEnd   = (stepCnt == CNT_W'(LAST_STEP));
  assign nextCnt = stepCnt + 1'b1;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    assign inSeg[i]    = (stepCnt >= CNT_W'(SEG_BREAK[i]));
    assign hitBreak[i] = (i != 0) && (nextCnt == CNT_W'(SEG_BREAK[i]));
  end

  always_comb begin
    segNow   = '0;
    breakIdx = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (inSeg[i])    segNow   = SEG_SEL_W'(i);
      if (hitBreak[i]) breakIdx = SEG_SEL_W'(i);
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.restart = restart;
    ctl.capture = accept;
    ctl.segSel  = segNow;
    if (accept && !atEnd) begin
      if (nextCnt == CNT_W'(LAST_STEP)) begin
        ctl.loadFloor = 1'b1;
      end else if (|hitBreak) begin
        ctl.loadStart = 1'b1;
        ctl.segSel    = breakIdx;
      end else begin
        ctl.stepDec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (restart) begin
      stepCnt <= '0;
    end else if (accept && !atEnd) begin
      stepCnt <= nextCnt;
    end
  end

endmodule

// File: rtl/stepgen_dp.sv
module stepgen_dp
  import stepgen_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ALPHA_W = 16,
  parameter int FRAC_W  = 8,
  localparam int ACC_W  = ALPHA_W + FRAC_W,
  localparam int PROD_W = DATA_W + ALPHA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [DATA_W-1:0] errIn,
  output logic [ALPHA_W-1:0] alphaQ16,
  output logic [DATA_W-1:0] updTerm,
  output logic              updValid
);

  logic [ACC_W-1:0] alphaAcc;
  logic [ACC_W-1:0] startTab [NUM_SEG];
  logic [ACC_W-1:0] decTab   [NUM_SEG];
  logic [ACC_W-1:0] startSel;
  logic [ACC_W-1:0] decSel;
  logic [ACC_W-1:0] resetVal;
  logic [ACC_W-1:0] floorVal;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_tab
    assign startTab[i] = ACC_W'(SEG_START[i]) << FRAC_W;
    assign decTab[i]   = ACC_W'(SEG_DEC[i]);
  end

  assign resetVal = ACC_W'(SEG_START[0]) << FRAC_W;
  assign floorVal = ACC_W'(FLOOR_ALPHA) << FRAC_W;

  always_comb begin
    startSel = startTab[0];
    decSel   = decTab[0];
    for (int i = 0; i < NUM_SEG; i++) begin
      if (ctl.segSel == SEG_SEL_W'(i)) begin
        startSel = startTab[i];
        decSel   = decTab[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alphaAcc <= resetVal;
    end else if (ctl.restart) begin
      alphaAcc <= resetVal;
    end else if (ctl.loadFloor) begin
      alphaAcc <= floorVal;
    end else if (ctl.loadStart) begin
      alphaAcc <= startSel;
    end else if (ctl.stepDec) begin
      alphaAcc <= alphaAcc - decSel;
    end
  end

  assign alphaQ16 = alphaAcc[FRAC_W +: ALPHA_W];

  // single shared multiply, rounded half up back to the error scale
  logic signed [PROD_W-1:0] prodFull;
  logic signed [PROD_W-1:0] roundSum;
  logic signed [PROD_W-1:0] roundBias;

  assign roundBias = PROD_W'(1) << (ALPHA_W - 1);
  assign prodFull  = $signed(errIn) * $signed({1'b0, alphaQ16});
  assign roundSum  = prodFull + roundBias;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updTerm  <= '0;
      updValid <= 1'b0;
    end else begin
      updValid <= ctl.capture;
      if (ctl.capture) updTerm <= roundSum[ALPHA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/stepgen_top.sv
module stepgen_top
  import stepgen_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ALPHA_W   = 16,
  parameter int FRAC_W    = 8,
  parameter int LAST_STEP = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] errIn,
  output logic [DATA_W-1:0] updTerm,
  output logic              updValid
);

  stepCtl_t           ctl;
  logic [ALPHA_W-1:0] alphaQ16;

  stepgen_ctrl #(.LAST_STEP(LAST_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart),
    .sampleValid(sampleValid), .ctl(ctl)
  );

  stepgen_dp #(.DATA_W(DATA_W), .ALPHA_W(ALPHA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .errIn(errIn),
    .alphaQ16(alphaQ16), .updTerm(updTerm), .updValid(updValid)
  );

endmodule

// File: rtl/stepgen_chk.sv
module stepgen_chk
  import stepgen_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ALPHA_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               restart,
  input logic               sampleValid,
  input logic [DATA_W-1:0]  updTerm,
  input logic               updValid,
  input logic [ALPHA_W-1:0] alphaQ16
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !restart) |=> updValid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && !restart) |=> (!updValid && $stable(updTerm)));

  assert_restart_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (alphaQ16 == ALPHA_W'(SEG_START[0]) && !updValid));

  assert_alpha_monotone_R7: assert property (@(posedge clk) disable iff (!rstN)
    !restart |=> (alphaQ16 <= $past(alphaQ16)));

  assert_alpha_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    alphaQ16 >= ALPHA_W'(FLOOR_ALPHA));

endmodule

bind stepgen_top stepgen_chk #(.DATA_W(DATA_W), .ALPHA_W(ALPHA_W)) u_chk (
  .clk(clk), .rstN(rstN), .restart(restart), .sampleValid(sampleValid),
  .updTerm(updTerm), .updValid(updValid), .alphaQ16(alphaQ16)
);

// File: tb/sim_stepgen_top.sv
`timescale 1ns/1ps
module sim_stepgen_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        restart = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] errIn = '0;
  logic [15:0] updTerm;
  logic        updValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int mCnt = 0;
  longint mAcc = 6554 * 256;

  always #2 clk = ~clk;

  stepgen_top u0 (
    .clk(clk), .rstN(rstN), .restart(restart), .sampleValid(sampleValid),
    .errIn(errIn), .updTerm(updTerm), .updValid(updValid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", req, act, exp, mCnt);
    end
  endtask

  function automatic string stageTag(input int n);
    if (n >= 1000) return "R5";
    if (n == 50 || n == 200) return "R4";
    return "R3";
  endfunction

  function automatic longint expTerm(input logic [15:0] e, input longint acc);
    longint a = acc / 256;
    longint p = longint'($signed(e)) * a + 32768;
    return p >>> 16;
  endfunction

  task automatic modelStep();
    int nc;
    if (mCnt < 1000) begin
      nc = mCnt + 1;
      if (nc == 1000) mAcc = 66 * 256;
      else if (nc == 50) mAcc = 1101 * 256;
      else if (nc == 200) mAcc = 315 * 256;
      else if (mCnt < 50) mAcc -= 27919;
      else if (mCnt < 200) mAcc -= 1341;
      else mAcc -= 79;
      mCnt = nc;
    end
  endtask

  function automatic logic [15:0] pickErr(input int k);
    case (k % 8)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      3: return 16'h0001;
      4: return 16'hFFFF;
      default: return 16'((k * 7919 + 12345) & 16'hFFFF);
    endcase
  endfunction

  task automatic sendSample(input logic [15:0] e, input bool_check_idle);
    longint exp;
    string tag;
    tag = stageTag(mCnt);
    exp = expTerm(e, mAcc);
    @(negedge clk);
    errIn = e;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check("R2 valid", updValid, 1);
    check(tag, longint'($signed(updTerm)), exp);
    modelStep();
    if (bool_check_idle) begin
      errIn = ~e;
      @(negedge clk);
      check("R8 valid", updValid, 0);
      check("R8 hold", longint'($signed(updTerm)), exp);
    end
  endtask

  typedef bit bool_check_idle_t;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", updValid, 0);
    check("R1 term", updTerm, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", updValid, 0);

    // first sample uses the reset value of alpha (R1)
    sendSample(16'h8000, 1'b1);

    for (int k = 1; k < 130; k++) sendSample(pickErr(k), (k % 10) == 0);

    // standalone restart (R6)
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check("R6 no output", updValid, 0);
    mCnt = 0; mAcc = 6554 * 256;
    sendSample(16'h7FFF, 1'b1);

    // full schedule through the floor and beyond (R3 R4 R5 R7)
    for (int k = 1; k < 1010; k++) sendSample(pickErr(k), (k % 25) == 0);
    check("R5 count saturated", mCnt, 1000);
    sendSample(16'h8000, 1'b0);
    sendSample(16'h7FFF, 1'b0);

    // restart together with a strobe: restart wins, no output (R6)
    @(negedge clk);
    restart = 1'b1;
    sampleValid = 1'b1;
    errIn = 16'h4000;
    @(negedge clk);
    restart = 1'b0;
    sampleValid = 1'b0;
    check("R6 priority", updValid, 0);
    mCnt = 0; mAcc = 6554 * 256;
    for (int k = 0; k < 6; k++) sendSample(pickErr(k), 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule